// File: doc/BRIEF.md
# Conversion Trigger and Sequencing Controller

This block decides when the decimation filter of one sigma-delta channel runs. It chooses between a software trigger and a hardware trigger. The hardware trigger first passes through a two-flop synchronizer and a polarity inversion. The selected trigger is then treated either as an edge event or as a level event.

From these events the controller drives a filter run flag and a single-cycle restart strobe. Three conversion policies set what happens when a further trigger arrives while a conversion is active:

- **Single:** run once, and restart on a new edge.
- **Continuous:** keep converting, and restart on a new edge.
- **Always:** keep converting, and ignore every later trigger.

In level mode, releasing the trigger cancels an active conversion in single and continuous policies.

Beside the sequencing, the block keeps an input-multiplexer index. The index either follows a configured select value, is loaded from it on each accepted trigger, or counts down on each accepted trigger and wraps back to the select value after reaching zero. The filter, the result storage and the register bus sit outside this block.

Top module: `conv_seq_ctrl`

## Requirements
- R1: `trig_src` = 0 takes `sw_trig` as the trigger and ignores `hw_trig`; `trig_src` = 1 takes the synchronized `hw_trig` and ignores `sw_trig`.
- R2: `hw_pol` = 0 makes a high level or rising edge of `hw_trig` active, and `hw_pol` = 1 makes a low level or falling edge active. A change on `hw_trig` reaches `filt_run` on the third rising clock edge after it.
- R3: In single policy (`conv_mode` = 00), an active trigger edge with the filter idle sets `filt_run` and `converting` at the next edge. A `filt_done` pulse then clears them at the next edge.
- R4: In edge mode (`lvl_mode` = 0) under single or continuous policy, a new active edge while running produces a one-cycle `filt_restart` and leaves `filt_run` high. `filt_restart` is never high unless `filt_run` was high the cycle before.
- R5: In continuous policy (`conv_mode` = 01), `filt_done` does not stop the conversion.
- R6: In always policy (`conv_mode` = 10), once running, later triggers, trigger release and `filt_done` have no effect: there is no restart, `filt_run` stays high, and the multiplexer index does not step.
- R7: In level mode (`lvl_mode` = 1) under single or continuous policy, the trigger going inactive clears `filt_run` at the next edge. Holding the trigger active never restarts.
- R8: `conv_mode` = 11 is reserved. In it no conversion starts, and `filt_run` is low from the edge after the code is applied.
- R9: With `mux_mode` = 00, `mux_idx` equals the `mux_sel` value sampled at the previous edge.
- R10: With `mux_mode` = 01, `mux_idx` is loaded from `mux_sel` on each accepted start or restart, and otherwise holds.
- R11: With `mux_mode` = 10, each accepted start or restart changes `mux_idx` to `mux_idx`-1, or to `mux_sel` when `mux_idx` is 0.
- R12: With `mux_mode` = 11 (reserved), `mux_idx` holds its value.
- R13: After synchronous reset, `filt_run`, `filt_restart`, `converting` and `mux_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_src | input | 1 | Trigger source: 0 software, 1 hardware |
| sw_trig | input | 1 | Software trigger level |
| hw_trig | input | 1 | Asynchronous hardware trigger |
| hw_pol | input | 1 | Hardware polarity: 0 high/rising, 1 low/falling |
| lvl_mode | input | 1 | 0 edge events, 1 level events |
| conv_mode | input | 2 | 00 single, 01 continuous, 10 always, 11 reserved |
| mux_mode | input | 2 | 00 follow, 01 preset, 10 scan, 11 reserved |
| mux_sel | input | MUXW | Configured multiplexer select |
| filt_done | input | 1 | Filter completion pulse |
| filt_run | output | 1 | Filter enable |
| filt_restart | output | 1 | One-cycle filter restart strobe |
| converting | output | 1 | Conversion in progress |
| mux_idx | output | MUXW | Current multiplexer index |

## Verification
The hardest state to reach from the ports is a scan-mode wraparound that coincides with a restart in a running conversion. It needs the index at zero, a live conversion and a fresh edge, all at once. The stimulus first presets the index to a known value, and then issues software trigger pulses under continuous policy so that every pulse after the first is a restart. This walks the index through zero several times while the select value is changed at random. Hardware-path latency and polarity are checked separately by counting edges after each `hw_trig` change.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    CM_SINGLE = 2'b00,
    CM_CONT   = 2'b01,
    CM_ALWAYS = 2'b10,
    CM_RSVD   = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    MX_FOLLOW = 2'b00,
    MX_PRESET = 2'b01,
    MX_SCAN   = 2'b10,
    MX_RSVD   = 2'b11
  } mux_mode_e;
endpackage

// File: rtl/trig_qualifier.sv
module trig_qualifier #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_src,
  input  logic sw_trig,
  input  logic hw_trig,
  input  logic hw_pol,
  output logic rise,
  output logic fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          act;
  logic          act_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q[0] <= hw_trig;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[LAST-1:0], hw_trig};
      end
    end
  endgenerate

  // active-sense trigger after source choice and polarity
  always_comb begin
    act = trig_src ? (sync_q[LAST] ^ hw_pol) : sw_trig;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  assign rise = act & ~act_q;
  assign fall = ~act & act_q;
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_mode,
  input  logic [1:0] conv_mode,
  input  logic       rise,
  input  logic       fall,
  input  logic       filt_done,
  output logic       run,
  output logic       restart,
  output logic       step
);
  conv_mode_e mode;
  logic       retrig_ok;
  logic       start_c;
  logic       restart_c;
  logic       cancel_c;
  logic       finish_c;

  always_comb begin
    mode      = conv_mode_e'(conv_mode);
    retrig_ok = (mode == CM_SINGLE) || (mode == CM_CONT);
    start_c   = !run && rise && (mode != CM_RSVD);
    restart_c = run && rise && !lvl_mode && retrig_ok;
    cancel_c  = run && fall && lvl_mode && retrig_ok;
    finish_c  = run && filt_done && (mode == CM_SINGLE) && !restart_c;
    step      = start_c || restart_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      restart <= 1'b0;
    end else begin
      restart <= restart_c;
      if (mode == CM_RSVD)          run <= 1'b0;
      else if (start_c)             run <= 1'b1;
      else if (cancel_c || finish_c) run <= 1'b0;
    end
  end
endmodule

// File: rtl/mux_indexer.sv
module mux_indexer
  import conv_seq_pkg::*;
#(
  parameter int MUXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mux_mode,
  input  logic [MUXW-1:0] mux_sel,
  input  logic            step,
  output logic [MUXW-1:0] idx
);
  localparam logic [MUXW-1:0] ZERO = '0;
  localparam logic [MUXW-1:0] ONE  = MUXW'(1);

  mux_mode_e       mode;
  logic [MUXW-1:0] scan_nxt;

  always_comb begin
    mode     = mux_mode_e'(mux_mode);
    scan_nxt = (idx == ZERO) ? mux_sel : idx - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= ZERO;
    end else begin
      case (mode)
        MX_FOLLOW: idx <= mux_sel;
        MX_PRESET: if (step) idx <= mux_sel;
        MX_SCAN:   if (step) idx <= scan_nxt;
        default:   idx <= idx;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int MUXW        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_src,
  input  logic            sw_trig,
  input  logic            hw_trig,
  input  logic            hw_pol,
  input  logic            lvl_mode,
  input  logic [1:0]      conv_mode,
  input  logic [1:0]      mux_mode,
  input  logic [MUXW-1:0] mux_sel,
  input  logic            filt_done,
  output logic            filt_run,
  output logic            filt_restart,
  output logic            converting,
  output logic [MUXW-1:0] mux_idx
);
  logic rise;
  logic fall;
  logic step;
  logic run;

  trig_qualifier #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .trig_src (trig_src),
    .sw_trig  (sw_trig),
    .hw_trig  (hw_trig),
    .hw_pol   (hw_pol),
    .rise     (rise),
    .fall     (fall)
  );

  conv_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .lvl_mode  (lvl_mode),
    .conv_mode (conv_mode),
    .rise      (rise),
    .fall      (fall),
    .filt_done (filt_done),
    .run       (run),
    .restart   (filt_restart),
    .step      (step)
  );

  mux_indexer #(.MUXW(MUXW)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .mux_mode (mux_mode),
    .mux_sel  (mux_sel),
    .step     (step),
    .idx      (mux_idx)
  );

  assign filt_run   = run;
  assign converting = run;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int MUXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            lvl_mode,
  input logic [1:0]      conv_mode,
  input logic [1:0]      mux_mode,
  input logic [MUXW-1:0] mux_sel,
  input logic            filt_run,
  input logic            filt_restart,
  input logic [MUXW-1:0] mux_idx
);
  AST_RESTART_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    filt_restart |-> ($past(filt_run) && filt_run)); // R4

  AST_CONT_IGNORES_DONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(conv_mode) == 2'b01 && !$past(lvl_mode) && $past(filt_run)) |-> filt_run); // R5

  AST_ALWAYS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(conv_mode) == 2'b10 && $past(filt_run)) |-> (filt_run && !filt_restart)); // R6

  AST_RSVD_CONV_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(conv_mode) == 2'b11) |-> !filt_run); // R8

  AST_MUX_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mux_mode) == 2'b00) |-> (mux_idx == $past(mux_sel))); // R9

  AST_MUX_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mux_mode) == 2'b11) |-> $stable(mux_idx)); // R12
endmodule

bind conv_seq_ctrl conv_seq_chk #(.MUXW(MUXW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lvl_mode     (lvl_mode),
  .conv_mode    (conv_mode),
  .mux_mode     (mux_mode),
  .mux_sel      (mux_sel),
  .filt_run     (filt_run),
  .filt_restart (filt_restart),
  .mux_idx      (mux_idx)
);

// File: tb/tb_conv_seq_ctrl.sv
module tb_conv_seq_ctrl;
  localparam int MUXW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trig_src = 1'b0;
  logic            sw_trig = 1'b0;
  logic            hw_trig = 1'b0;
  logic            hw_pol = 1'b0;
  logic            lvl_mode = 1'b0;
  logic [1:0]      conv_mode = 2'b00;
  logic [1:0]      mux_mode = 2'b00;
  logic [MUXW-1:0] mux_sel = '0;
  logic            filt_done = 1'b0;
  logic            filt_run;
  logic            filt_restart;
  logic            converting;
  logic [MUXW-1:0] mux_idx;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  always #2 clk = ~clk;

  conv_seq_ctrl #(.MUXW(MUXW)) dut (
    .clk(clk), .rst(rst), .trig_src(trig_src), .sw_trig(sw_trig),
    .hw_trig(hw_trig), .hw_pol(hw_pol), .lvl_mode(lvl_mode),
    .conv_mode(conv_mode), .mux_mode(mux_mode), .mux_sel(mux_sel),
    .filt_done(filt_done), .filt_run(filt_run), .filt_restart(filt_restart),
    .converting(converting), .mux_idx(mux_idx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // software pulse: high for one edge, then low for one edge
  task automatic pulse();
    sw_trig = 1'b1; tick();
    sw_trig = 1'b0; tick();
  endtask

  function automatic logic [MUXW-1:0] scan_next(input logic [MUXW-1:0] cur,
                                                 input logic [MUXW-1:0] sel);
    return (cur == '0) ? sel : cur - 1'b1;
  endfunction

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [MUXW-1:0] model;
    seed_dummy = $urandom(32'h5eed_0c0d);
    tick(); tick(); tick();
    // R13 reset state
    check("R13 run", filt_run, 0);
    check("R13 restart", filt_restart, 0);
    check("R13 converting", converting, 0);
    check("R13 idx", mux_idx, 0);
    rst = 1'b0;
    tick();

    // R1/R3 single policy from software trigger
    conv_mode = 2'b00;
    sw_trig = 1'b1; tick();
    check("R3 start", filt_run, 1);
    check("R3 converting", converting, 1);
    sw_trig = 1'b0; tick();
    check("R3 still running", filt_run, 1);
    filt_done = 1'b1; tick(); filt_done = 1'b0;
    check("R3 done stops", filt_run, 0);
    check("R3 converting low", converting, 0);

    // R4 edge retrigger in single policy
    pulse();
    check("R4 running", filt_run, 1);
    sw_trig = 1'b1; tick();
    check("R4 restart strobe", filt_restart, 1);
    check("R4 run kept", filt_run, 1);
    sw_trig = 1'b0; tick();
    check("R4 strobe one cycle", filt_restart, 0);
    filt_done = 1'b1; tick(); filt_done = 1'b0;
    check("R3 done after restart", filt_run, 0);

    // R5 continuous ignores done
    conv_mode = 2'b01;
    pulse();
    filt_done = 1'b1; tick(); filt_done = 1'b0;
    check("R5 done ignored", filt_run, 1);
    // R8 reserved clears and blocks start
    conv_mode = 2'b11; tick();
    check("R8 reserved clears", filt_run, 0);
    pulse();
    check("R8 no start", filt_run, 0);

    // R6 always policy
    conv_mode = 2'b10;
    mux_mode = 2'b01; mux_sel = 3'd5;
    pulse();
    check("R6 start", filt_run, 1);
    check("R10 preset on start", mux_idx, 5);
    mux_sel = 3'd2;
    sw_trig = 1'b1; tick();
    check("R6 no restart", filt_restart, 0);
    sw_trig = 1'b0; tick();
    check("R6 index not stepped", mux_idx, 5);
    filt_done = 1'b1; tick(); filt_done = 1'b0;
    check("R6 done ignored", filt_run, 1);
    conv_mode = 2'b11; tick();

    // R7 level mode cancellation
    for (int m = 0; m < 2; m++) begin
      conv_mode = m[1:0];
      lvl_mode = 1'b1;
      sw_trig = 1'b1; tick();
      check("R7 level start", filt_run, 1);
      tick(); tick();
      check("R7 no restart held", filt_restart, 0);
      check("R7 held running", filt_run, 1);
      sw_trig = 1'b0; tick();
      check("R7 release cancels", filt_run, 0);
    end
    lvl_mode = 1'b0;

    // R1/R2 hardware path
    conv_mode = 2'b01; trig_src = 1'b1; hw_pol = 1'b0;
    tick(); tick();
    pulse();
    check("R1 sw ignored on hw source", filt_run, 0);
    hw_trig = 1'b1; tick();
    check("R2 latency edge1", filt_run, 0);
    tick();
    check("R2 latency edge2", filt_run, 0);
    tick();
    check("R2 rise starts on edge3", filt_run, 1);
    conv_mode = 2'b11; tick();
    hw_pol = 1'b1; tick();
    conv_mode = 2'b01; tick(); tick();
    check("R2 inverted idle", filt_run, 0);
    hw_trig = 1'b0; tick(); tick();
    check("R2 falling not yet", filt_run, 0);
    tick();
    check("R2 falling starts", filt_run, 1);
    conv_mode = 2'b11; tick();
    trig_src = 1'b0; hw_pol = 1'b0;
    hw_trig = 1'b1; tick(); tick(); tick();
    conv_mode = 2'b01; tick();
    pulse();
    check("R1 hw ignored on sw source", filt_run, 1);

    // R9 follow with random selects
    mux_mode = 2'b00;
    for (int i = 0; i < 8; i++) begin
      mux_sel = MUXW'($urandom);
      tick();
      check("R9 follow", mux_idx, int'(mux_sel));
    end

    // R10 preset on restart, hold otherwise
    mux_mode = 2'b01; mux_sel = 3'd4; tick();
    pulse();
    check("R10 preset restart", mux_idx, 4);
    mux_sel = 3'd6; tick();
    check("R10 hold without trigger", mux_idx, 4);
    pulse();
    check("R10 preset second", mux_idx, 6);

    // R11 directed wrap
    mux_sel = 3'd2; pulse();
    mux_mode = 2'b10;
    pulse(); check("R11 dec to 1", mux_idx, 1);
    pulse(); check("R11 dec to 0", mux_idx, 0);
    pulse(); check("R11 wrap to sel", mux_idx, 2);
    pulse(); check("R11 dec after wrap", mux_idx, 1);

    // R11 random scan with restarts
    model = mux_idx;
    for (int i = 0; i < 24; i++) begin
      if (($urandom % 4) == 0) mux_sel = MUXW'($urandom);
      model = scan_next(model, mux_sel);
      sw_trig = 1'b1; tick();
      check("R4 restart in scan", filt_restart, 1);
      sw_trig = 1'b0; tick();
      check("R11 scan random", mux_idx, int'(model));
    end

    // R12 reserved mux mode holds
    mux_mode = 2'b11;
    model = mux_idx;
    mux_sel = model + 3'd3;
    pulse();
    check("R12 hold", mux_idx, int'(model));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule